// File: doc/BRIEF.md
# Light-Load Mode Detector with Debounce

This block decides, from a stream of digitized output-current samples, whether a power converter should run in light-load mode. Two thresholds form a hysteresis band: a sample below the lower (entry) threshold moves the block into light-load mode. Only a sample at or above the upper (exit) threshold brings it back. After any mode change, a programmable hold-off interval blocks the next change. This stops the converter from chattering between modes when the thresholds are close together.

In light-load mode both synchronous-rectifier enables are withdrawn. Any other PWM output whose bit is set in a shed mask is also withdrawn. On leaving light-load mode, the withdrawn outputs come back only after a selectable re-enable delay of 1x, 2x, 4x or 8x a base time. At 125 MHz with the default parameters this gives 37.5, 75, 150 or 300 µs. A one-cycle exit pulse lets a downstream soft-start block begin a fresh ramp. Current-sense filtering and PWM generation sit outside this block.

Top module: `llm_detect`

## Requirements
- R1: In normal mode, a valid sample (`cs_valid_i`=1) strictly below `thr_enter_i` sets `light_mode_o` at that clock edge, provided the debounce hold-off has expired. A sample equal to the threshold does not.
- R2: In light-load mode, a valid sample at or above `thr_exit_i` clears `light_mode_o` at that clock edge, provided the hold-off has expired. A sample below `thr_exit_i` leaves the block in light-load mode.
- R3: Each mode change starts a hold-off of L = DEB_BASE_CYC·2^`deb_sel_i` cycles, with code 0..3 giving 1x, 2x, 4x, 8x. The code is sampled at the change. A change at edge k blocks any further change at edges k+1 .. k+L-1. Edge k+L may change mode again.
- R4: While `light_mode_o`=1, `sr_en_o` is 2'b00.
- R5: After leaving light-load mode at edge k, `sr_en_o` stays 2'b00 until edge k+R and reads 2'b11 from then on. R = REEN_BASE_CYC·2^`reen_sel_i`, with code 0..3 giving 1x, 2x, 4x, 8x, and the code is sampled at the exit.
- R6: For each bit i, `pwm_en_o[i]` = 1 whenever `pwm_shed_mask_i[i]`=0. When the mask bit is set, `pwm_en_o[i]` equals the SR enable condition: low in light-load mode and during the re-enable delay.
- R7: `exit_pulse_o` is high for exactly the one cycle after the edge at which light-load mode is left, and is never high otherwise.
- R8: During and right after reset: `light_mode_o`=0, `sr_en_o`=2'b11, all `pwm_en_o` bits 1, `exit_pulse_o`=0, and the hold-off is expired.
- R9: A sample with `cs_valid_i`=0 has no effect on the mode, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_valid_i | input | 1 | Current-sense sample strobe |
| cs_data_i | input | CS_W | Current-sense sample, unsigned |
| thr_enter_i | input | CS_W | Light-load entry threshold (enter when below) |
| thr_exit_i | input | CS_W | Light-load exit threshold (leave when at or above) |
| deb_sel_i | input | 2 | Hold-off length code |
| reen_sel_i | input | 2 | Re-enable delay code |
| pwm_shed_mask_i | input | NUM_PWM | Outputs to shed in light-load mode |
| light_mode_o | output | 1 | Light-load mode flag |
| sr_en_o | output | 2 | Synchronous-rectifier enables |
| pwm_en_o | output | NUM_PWM | Other PWM output enables |
| exit_pulse_o | output | 1 | One-cycle pulse on leaving light-load mode |

## Verification
The mode flag and the exit pulse are registered, so a sample presented before edge n is reflected in the cycle after edge n. The re-enable delay completes R edges after the exit edge, and the hold-off admits the next change L edges after the previous one. The enables are combinational from registered state and the live shed mask. The bench drives inputs on the falling edge and advances a cycle-indexed model at every rising edge. At the next falling edge, before it drives new inputs, it compares every output against that model. This way each result is checked in exactly the cycle the requirements predict.

// File: rtl/llm_pkg.sv
package llm_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_LIGHT  = 1'b1
  } mode_e;

  localparam int NUM_SR = 2;
endpackage

// File: rtl/llm_compare.sv
module llm_compare #(
  parameter int CS_W = 12
) (
  input  logic [CS_W-1:0] data_i,
  input  logic [CS_W-1:0] thr_enter_i,
  input  logic [CS_W-1:0] thr_exit_i,
  output logic            below_enter_o,
  output logic            above_exit_o
);
  assign below_enter_o = data_i < thr_enter_i;
  assign above_exit_o  = data_i >= thr_exit_i;
endmodule

// File: rtl/llm_timer.sv
module llm_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) && ($past(load_val_i) != '0) |-> !zero_o); // R3
endmodule

// File: rtl/llm_out_gate.sv
module llm_out_gate #(
  parameter int NUM_PWM = 6
) (
  input  logic               outputs_ok_i,
  input  logic [NUM_PWM-1:0] shed_mask_i,
  output logic [1:0]         sr_en_o,
  output logic [NUM_PWM-1:0] pwm_en_o
);
  assign sr_en_o = {2{outputs_ok_i}};

  for (genvar i = 0; i < NUM_PWM; i++) begin : g_pwm
    assign pwm_en_o[i] = !shed_mask_i[i] || outputs_ok_i;
  end
endmodule

// File: rtl/llm_detect.sv
module llm_detect
  import llm_pkg::*;
#(
  parameter int CS_W          = 12,
  parameter int NUM_PWM       = 6,
  parameter int DEB_BASE_CYC  = 12500,
  parameter int REEN_BASE_CYC = 4688
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_valid_i,
  input  logic [CS_W-1:0]    cs_data_i,
  input  logic [CS_W-1:0]    thr_enter_i,
  input  logic [CS_W-1:0]    thr_exit_i,
  input  logic [1:0]         deb_sel_i,
  input  logic [1:0]         reen_sel_i,
  input  logic [NUM_PWM-1:0] pwm_shed_mask_i,
  output logic               light_mode_o,
  output logic [1:0]         sr_en_o,
  output logic [NUM_PWM-1:0] pwm_en_o,
  output logic               exit_pulse_o
);
  localparam int DEB_W  = $clog2(DEB_BASE_CYC * 8 + 1);
  localparam int REEN_W = $clog2(REEN_BASE_CYC * 8 + 1);

  mode_e mode_q;
  logic  exit_pulse_q;
  logic  below_enter, above_exit;
  logic  deb_zero, reen_zero;
  logic  enter_fire, exit_fire, change;
  logic [DEB_W-1:0]  deb_len, deb_load;
  logic [REEN_W-1:0] reen_len;

  llm_compare #(.CS_W(CS_W)) u_cmp (
    .data_i       (cs_data_i),
    .thr_enter_i  (thr_enter_i),
    .thr_exit_i   (thr_exit_i),
    .below_enter_o(below_enter),
    .above_exit_o (above_exit)
  );

  assign enter_fire = cs_valid_i && deb_zero && (mode_q == MODE_NORMAL) && below_enter;
  assign exit_fire  = cs_valid_i && deb_zero && (mode_q == MODE_LIGHT)  && above_exit;
  assign change     = enter_fire || exit_fire;

  // hold-off loads L-1 so the next change is legal exactly L edges later
  assign deb_len  = DEB_W'(DEB_BASE_CYC) << deb_sel_i;
  assign deb_load = deb_len - 1'b1;
  assign reen_len = REEN_W'(REEN_BASE_CYC) << reen_sel_i;

  llm_timer #(.W(DEB_W)) u_deb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (change),
    .load_val_i(deb_load),
    .zero_o    (deb_zero)
  );

  llm_timer #(.W(REEN_W)) u_reen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (exit_fire),
    .load_val_i(reen_len),
    .zero_o    (reen_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_NORMAL;
      exit_pulse_q <= 1'b0;
    end else begin
      if (enter_fire)     mode_q <= MODE_LIGHT;
      else if (exit_fire) mode_q <= MODE_NORMAL;
      exit_pulse_q <= exit_fire;
    end
  end

  llm_out_gate #(.NUM_PWM(NUM_PWM)) u_gate (
    .outputs_ok_i(mode_q == MODE_NORMAL && reen_zero),
    .shed_mask_i (pwm_shed_mask_i),
    .sr_en_o     (sr_en_o),
    .pwm_en_o    (pwm_en_o)
  );

  assign light_mode_o = (mode_q == MODE_LIGHT);
  assign exit_pulse_o = exit_pulse_q;

  AST_ENTER_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(light_mode_o) |-> $past(cs_valid_i && (cs_data_i < thr_enter_i))); // R1
  AST_EXIT_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(light_mode_o) |-> $past(cs_valid_i && (cs_data_i >= thr_exit_i))); // R2
  AST_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (light_mode_o != $past(light_mode_o)) |-> $past(deb_zero)); // R3
  AST_SR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    light_mode_o |-> (sr_en_o == 2'b00)); // R4
  AST_SHED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    light_mode_o |-> ((pwm_en_o & pwm_shed_mask_i) == '0)); // R6
  AST_PULSE_ON_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_pulse_o |-> $fell(light_mode_o)); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_pulse_o |=> !exit_pulse_o); // R7
endmodule

// File: tb/tb_llm_detect.sv
module tb_llm_detect;
  localparam int CS_W = 10;
  localparam int NP   = 4;
  localparam int DEB  = 3;
  localparam int REEN = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_valid = 1'b0;
  logic [CS_W-1:0] cs_data = '0, thr_enter = 10'd200, thr_exit = 10'd300;
  logic [1:0] deb_sel = '0, reen_sel = '0;
  logic [NP-1:0] mask = '0;
  logic light;
  logic [1:0] sr_en;
  logic [NP-1:0] pwm_en;
  logic exit_pulse;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  // model state
  bit m_light = 0, m_have_tr = 0, m_have_exit = 0;
  int m_last_tr = 0, m_len = 0, m_exit = 0, m_rlen = 0;
  string m_tag = "R8";

  always #4 clk = ~clk;

  llm_detect #(.CS_W(CS_W), .NUM_PWM(NP), .DEB_BASE_CYC(DEB), .REEN_BASE_CYC(REEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_valid_i(cs_valid), .cs_data_i(cs_data),
    .thr_enter_i(thr_enter), .thr_exit_i(thr_exit), .deb_sel_i(deb_sel),
    .reen_sel_i(reen_sel), .pwm_shed_mask_i(mask), .light_mode_o(light),
    .sr_en_o(sr_en), .pwm_en_o(pwm_en), .exit_pulse_o(exit_pulse)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit ok_now();
    return !m_light && (!m_have_exit || (cyc - m_exit >= m_rlen));
  endfunction

  task automatic check_all();
    bit ok = ok_now();
    logic [NP-1:0] ep = ~mask | {NP{ok}};
    chk(m_tag, "light_mode", int'(light), int'(m_light));
    chk(m_light ? "R4" : "R5", "sr_en", int'(sr_en), ok ? 3 : 0);
    chk("R6", "pwm_en", int'(pwm_en), int'(ep));
    chk("R7", "exit_pulse", int'(exit_pulse), int'(m_have_exit && m_exit == cyc));
  endtask

  // advance one rising edge and update the model with the held inputs
  task automatic tick();
    bit allowed;
    @(posedge clk);
    cyc++;
    allowed = !m_have_tr || (cyc - m_last_tr >= m_len);
    if (!cs_valid) m_tag = "R9";
    else if (!allowed) m_tag = "R3";
    else if (!m_light && cs_data < thr_enter) begin
      m_light = 1; m_have_tr = 1; m_last_tr = cyc; m_len = DEB << deb_sel; m_tag = "R1";
    end else if (m_light && cs_data >= thr_exit) begin
      m_light = 0; m_have_tr = 1; m_last_tr = cyc; m_len = DEB << deb_sel;
      m_have_exit = 1; m_exit = cyc; m_rlen = REEN << reen_sel; m_tag = "R2";
    end else m_tag = m_light ? "R2" : "R1";
    @(negedge clk);
    check_all();
  endtask

  task automatic drive(input bit v, input int d);
    cs_valid = v; cs_data = CS_W'(d);
  endtask

  function automatic int pick_data();
    case ($urandom_range(5))
      0: return 199;
      1: return 200;
      2: return 299;
      3: return 300;
      default: return int'($urandom_range(511));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2024));
    mask = 4'b1010;
    #1;
    chk("R8", "light in reset", int'(light), 0);
    chk("R8", "sr_en in reset", int'(sr_en), 3);
    chk("R8", "pwm_en in reset", int'(pwm_en), 4'hF);
    chk("R8", "exit_pulse in reset", int'(exit_pulse), 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    check_all();
    // R9: invalid low sample ignored
    drive(0, 0); tick(); tick();
    // R1 boundary: equal to entry threshold does not enter
    drive(1, 200); tick();
    drive(1, 199); tick();
    // R3: exit attempt inside hold-off, then legal
    drive(1, 300); deb_sel = 2'd1; reen_sel = 2'd2;
    for (int i = 0; i < 8; i++) tick();
    // R2 boundary: just below exit keeps light
    drive(0, 0);
    for (int i = 0; i < 30; i++) tick();
    drive(1, 150); tick();
    drive(1, 299); for (int i = 0; i < 8; i++) tick();
    // R5: each re-enable code
    for (int s = 0; s < 4; s++) begin
      reen_sel = 2'(s); deb_sel = 2'd0;
      drive(1, 100); for (int i = 0; i < 4; i++) tick();
      drive(1, 400); tick();
      drive(0, 0); for (int i = 0; i < (REEN << s) + 4; i++) tick();
    end
    // random phase
    for (int n = 0; n < 4000; n++) begin
      cs_valid = ($urandom_range(9) < 7);
      cs_data = CS_W'(pick_data());
      if ($urandom_range(19) == 0) deb_sel = 2'($urandom_range(3));
      if ($urandom_range(19) == 0) reen_sel = 2'($urandom_range(3));
      if ($urandom_range(49) == 0) mask = NP'($urandom_range(15));
      tick();
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule